// File: doc/BRIEF.md
# ADC Conversion Step Sequencer

The block schedules conversions on one shared analog-to-digital converter from a table of sixteen programmable steps. Every step owns a configuration word and a delay word. A start pulse captures a step-enable mask; the sequencer then visits the enabled steps in ascending index order. For each step it waits that step's open delay, then repeats a sample delay plus one conversion as many times as the step's averaging code asks. The averaged 12-bit result goes out on a result write port, routed to one of two result queues and optionally tagged with the step index. When the last enabled step is written, a one-cycle end-of-sequence pulse is raised.

Steps may be one-shot (dropped from the active mask after they run), continuous (kept), or hardware-synchronised (kept, and each run waits for a trigger input). While the sequence enable input is high and steps remain in the active mask, the sequencer restarts from the lowest enabled step, first running a charge interval of programmable length if mask bit 0 is set. The converter sits behind a start/done handshake with 12-bit data. Fields for analog multiplexing, references and bias switching are stored in the table but not interpreted.

The controller states are IDLE, SETUP, HWWAIT, OPEN, SAMPLE, CONV_REQ, CONV_WAIT, WRITE, EOS and CHARGE. Transitions: IDLE to SETUP on a start pulse with a nonzero step mask; SETUP to HWWAIT for a hardware-synchronised step, else to OPEN; HWWAIT to OPEN when the trigger is high; OPEN to SAMPLE and SAMPLE to CONV_REQ when the delay count reaches zero; CONV_REQ to CONV_WAIT always; CONV_WAIT to SAMPLE on a converter done that is not the last sample, to WRITE on the last; WRITE to SETUP when a higher enabled step exists, else to EOS; EOS to CHARGE (mask bit 0 set) or SETUP when the enable is high and steps remain, else to IDLE; CHARGE to SETUP when its count reaches zero.

Top module: `adc_step_sequencer`

## Requirements
- R1: After reset `busy`, `adc_start`, `res_valid` and `eos` are low.
- R2: Step i is enabled by mask bit i+1; enabled steps produce exactly one result each per pass, in ascending index order, and disabled steps produce none.
- R3: A step with averaging code c (config bits 4:2) issues 2^c conversions and its result bits 11:0 equal the sum of those samples shifted right by c.
- R4: A step's first converter request comes no sooner than open delay (delay bits 17:0) plus sample delay (delay bits 31:24) cycles after the step begins.
- R5: `res_fifo1` equals config bit 26 of the step that produced the result.
- R6: Result bits 15:12 are zero; bits 19:16 carry the step index when `tag_id` was high at capture, else zero.
- R7: `eos` is a one-cycle pulse in the cycle right after the last result of a pass, with `busy` low in that cycle and `busy` high while any step is in progress.
- R8: Mode code 0 (config bits 1:0) removes the step from the active mask after it runs; mode 1 keeps it; with `seq_enable` high and steps remaining the pass repeats, and with `seq_enable` low the block returns to idle after end-of-sequence.
- R9: A step with mode code 2 or 3 issues no converter request until `hw_trig` has been seen high.
- R10: With mask bit 0 set, at least `chg_open_dly` cycles pass between an end-of-sequence pulse and the next pass's first converter request.
- R11: A start pulse is ignored while busy and when the mask has no step bit set.
- R12: A new `adc_start` never comes while a conversion is outstanding (after `adc_start`, before `adc_done`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tbl_we | input | 1 | Step table write strobe |
| tbl_addr | input | 4 | Step index to write |
| tbl_cfg | input | 32 | Configuration word for the step |
| tbl_dly | input | 32 | Delay word for the step |
| chg_open_dly | input | 18 | Charge interval length in cycles |
| step_mask | input | 17 | Bit 0 charge enable, bit i+1 step i enable |
| seq_start | input | 1 | Start pulse, captures the mask |
| seq_enable | input | 1 | Allows passes to repeat |
| tag_id | input | 1 | Place step index in result bits 19:16 |
| hw_trig | input | 1 | Trigger for hardware-synchronised steps |
| adc_start | output | 1 | Converter request pulse |
| adc_done | input | 1 | Converter completion pulse |
| adc_data | input | 12 | Converter sample, valid with done |
| res_valid | output | 1 | Result write strobe |
| res_fifo1 | output | 1 | 1 selects the second result queue |
| res_data | output | 20 | Result word |
| eos | output | 1 | End-of-sequence pulse |
| busy | output | 1 | A pass is in progress |

## Verification
Every cycle the assertions check the converter handshake discipline (no request while one is outstanding), the shape of end-of-sequence (single cycle, after a result, busy low), that results appear only while busy, and the zero and tag fields of each result word. Only the bench scenarios show the arithmetic of the averages, the ascending visit order with gaps in the mask, queue routing, minimum delay and charge intervals, one-shot removal versus continuous repetition, trigger gating, and that start pulses are ignored while busy or with an empty mask.

// File: rtl/seq_pkg.sv
package seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SETUP,
        ST_HWWAIT,
        ST_OPEN,
        ST_SAMPLE,
        ST_CONV_REQ,
        ST_CONV_WAIT,
        ST_WRITE,
        ST_EOS,
        ST_CHARGE
    } seq_state_t;

    // Decoded positions inside the configuration word
    localparam int CFG_MODE_LSB = 0;
    localparam int CFG_AVG_LSB  = 2;
    localparam int CFG_FIFO_BIT = 26;
    localparam int CFG_HW_BIT   = 1;   // mode codes 2 and 3

    // Decoded positions inside the delay word
    localparam int DLY_OPEN_LSB = 0;
    localparam int DLY_SAMP_LSB = 24;

    // Result word layout
    localparam int RES_TAG_LSB  = 16;

endpackage

// File: rtl/seq_step_table.sv
module seq_step_table #(
    parameter int NUM_STEPS = 16,
    parameter int WORD_W    = 32,
    localparam int IW       = $clog2(NUM_STEPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IW-1:0]     waddr,
    input  logic [WORD_W-1:0] wcfg,
    input  logic [WORD_W-1:0] wdly,
    input  logic [IW-1:0]     raddr,
    output logic [WORD_W-1:0] rcfg,
    output logic [WORD_W-1:0] rdly
);

    logic [WORD_W-1:0] cfg_mem [NUM_STEPS];
    logic [WORD_W-1:0] dly_mem [NUM_STEPS];

    for (genvar e = 0; e < NUM_STEPS; e++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_mem[e] <= '0;
                dly_mem[e] <= '0;
            end else if (we && (waddr == IW'(e))) begin
                cfg_mem[e] <= wcfg;
                dly_mem[e] <= wdly;
            end
        end
    end

    assign rcfg = cfg_mem[raddr];
    assign rdly = dly_mem[raddr];

endmodule

// File: rtl/seq_next_finder.sv
module seq_next_finder #(
    parameter int NUM_STEPS = 16,
    localparam int IW       = $clog2(NUM_STEPS)
) (
    input  logic [NUM_STEPS-1:0] mask,
    input  logic [IW:0]          base,
    output logic                 found,
    output logic [IW-1:0]        idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < NUM_STEPS; i++) begin
            if (!found && mask[i] && (i >= int'(base))) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/seq_avg_accum.sv
module seq_avg_accum #(
    parameter int RES_W  = 12,
    parameter int AVG_W  = 3,
    localparam int MAXSH = (1 << AVG_W) - 1,
    localparam int SUM_W = RES_W + MAXSH,
    localparam int CNT_W = MAXSH + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             add,
    input  logic [RES_W-1:0] sample,
    input  logic [AVG_W-1:0] code,
    output logic             last,
    output logic [RES_W-1:0] avg
);

    logic [SUM_W-1:0] sum_q;
    logic [CNT_W-1:0] cnt_q;
    logic [SUM_W-1:0] sum_next;
    logic [CNT_W-1:0] target;

    assign sum_next = sum_q + SUM_W'(sample);
    assign target   = CNT_W'(1) << code;
    assign last     = (cnt_q + CNT_W'(1)) == target;
    assign avg      = RES_W'(sum_next >> code);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q <= '0;
            cnt_q <= '0;
        end else if (clr) begin
            sum_q <= '0;
            cnt_q <= '0;
        end else if (add) begin
            sum_q <= sum_next;
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/adc_step_sequencer.sv
module adc_step_sequencer
    import seq_pkg::*;
#(
    parameter int NUM_STEPS = 16,
    parameter int RES_W     = 12,
    parameter int OPEN_W    = 18,
    parameter int SAMP_W    = 8,
    parameter int AVG_W     = 3,
    parameter int WORD_W    = 32,
    localparam int IW       = $clog2(NUM_STEPS),
    localparam int OUT_W    = RES_TAG_LSB + IW,
    localparam int MASK_W   = NUM_STEPS + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tbl_we,
    input  logic [IW-1:0]     tbl_addr,
    input  logic [WORD_W-1:0] tbl_cfg,
    input  logic [WORD_W-1:0] tbl_dly,
    input  logic [OPEN_W-1:0] chg_open_dly,
    input  logic [MASK_W-1:0] step_mask,
    input  logic              seq_start,
    input  logic              seq_enable,
    input  logic              tag_id,
    input  logic              hw_trig,
    output logic              adc_start,
    input  logic              adc_done,
    input  logic [RES_W-1:0]  adc_data,
    output logic              res_valid,
    output logic              res_fifo1,
    output logic [OUT_W-1:0]  res_data,
    output logic              eos,
    output logic              busy
);

    seq_state_t state_q, state_d;

    logic [MASK_W-1:0] act_mask_q;
    logic [IW-1:0]     idx_q;
    logic [OPEN_W-1:0] cnt_q;
    logic [OUT_W-1:0]  res_q;
    logic              fifo_q;

    logic [WORD_W-1:0] cur_cfg, cur_dly;
    logic [NUM_STEPS-1:0] pick_mask;
    logic [IW:0]       pick_base;
    logic              pick_found;
    logic [IW-1:0]     pick_idx;
    logic              acc_last;
    logic [RES_W-1:0]  acc_avg;
    logic              acc_clr, acc_add;

    logic [1:0]        cur_mode;
    logic [AVG_W-1:0]  cur_avg;
    logic [OPEN_W-1:0] cur_open;
    logic [SAMP_W-1:0] cur_samp;
    logic              cnt_zero;

    assign cur_mode = cur_cfg[CFG_MODE_LSB +: 2];
    assign cur_avg  = cur_cfg[CFG_AVG_LSB +: AVG_W];
    assign cur_open = cur_dly[DLY_OPEN_LSB +: OPEN_W];
    assign cur_samp = cur_dly[DLY_SAMP_LSB +: SAMP_W];
    assign cnt_zero = (cnt_q == '0);

    // Fields kept for the analog front end are stored but not decoded here
    logic unused_fields;
    assign unused_fields = ^{cur_cfg, cur_dly};

    seq_step_table #(.NUM_STEPS(NUM_STEPS), .WORD_W(WORD_W)) u_table (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (tbl_we),
        .waddr (tbl_addr),
        .wcfg  (tbl_cfg),
        .wdly  (tbl_dly),
        .raddr (idx_q),
        .rcfg  (cur_cfg),
        .rdly  (cur_dly)
    );

    assign pick_mask = (state_q == ST_IDLE) ? step_mask[MASK_W-1:1]
                                            : act_mask_q[MASK_W-1:1];
    assign pick_base = (state_q == ST_WRITE) ? ((IW+1)'(idx_q) + (IW+1)'(1))
                                             : '0;

    seq_next_finder #(.NUM_STEPS(NUM_STEPS)) u_finder (
        .mask  (pick_mask),
        .base  (pick_base),
        .found (pick_found),
        .idx   (pick_idx)
    );

    assign acc_clr = (state_q == ST_SETUP);
    assign acc_add = (state_q == ST_CONV_WAIT) && adc_done;

    seq_avg_accum #(.RES_W(RES_W), .AVG_W(AVG_W)) u_accum (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (acc_clr),
        .add    (acc_add),
        .sample (adc_data),
        .code   (cur_avg),
        .last   (acc_last),
        .avg    (acc_avg)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (seq_start && pick_found) state_d = ST_SETUP;
            ST_SETUP:     state_d = cur_mode[CFG_HW_BIT] ? ST_HWWAIT : ST_OPEN;
            ST_HWWAIT:    if (hw_trig) state_d = ST_OPEN;
            ST_OPEN:      if (cnt_zero) state_d = ST_SAMPLE;
            ST_SAMPLE:    if (cnt_zero) state_d = ST_CONV_REQ;
            ST_CONV_REQ:  state_d = ST_CONV_WAIT;
            ST_CONV_WAIT: if (adc_done) state_d = acc_last ? ST_WRITE : ST_SAMPLE;
            ST_WRITE:     state_d = pick_found ? ST_SETUP : ST_EOS;
            ST_EOS: begin
                if (seq_enable && pick_found)
                    state_d = act_mask_q[0] ? ST_CHARGE : ST_SETUP;
                else
                    state_d = ST_IDLE;
            end
            ST_CHARGE:    if (cnt_zero) state_d = ST_SETUP;
            default:      state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_mask_q <= '0;
            idx_q      <= '0;
            cnt_q      <= '0;
            res_q      <= '0;
            fifo_q     <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && state_d == ST_SETUP)
                act_mask_q <= step_mask;
            else if (state_q == ST_WRITE && cur_mode == 2'd0)
                act_mask_q[(IW+1)'(idx_q) + (IW+1)'(1)] <= 1'b0;

            if (state_d == ST_SETUP && state_q != ST_SETUP)
                idx_q <= pick_idx;

            unique case (state_q)
                ST_SETUP:     cnt_q <= cur_open;
                ST_OPEN:      cnt_q <= cnt_zero ? OPEN_W'(cur_samp) : cnt_q - 1'b1;
                ST_SAMPLE,
                ST_CHARGE:    if (!cnt_zero) cnt_q <= cnt_q - 1'b1;
                ST_CONV_WAIT: if (adc_done && !acc_last) cnt_q <= OPEN_W'(cur_samp);
                ST_EOS:       cnt_q <= chg_open_dly;
                default:      cnt_q <= cnt_q;
            endcase

            if (acc_add && acc_last) begin
                res_q  <= {(tag_id ? idx_q : IW'(0)),
                           (RES_TAG_LSB - RES_W)'(0), acc_avg};
                fifo_q <= cur_cfg[CFG_FIFO_BIT];
            end
        end
    end

    // Outputs
    always_comb begin
        adc_start = (state_q == ST_CONV_REQ);
        res_valid = (state_q == ST_WRITE);
        eos       = (state_q == ST_EOS);
        busy      = (state_q != ST_IDLE) && (state_q != ST_EOS);
        res_fifo1 = fifo_q;
        res_data  = res_q;
    end

endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
    parameter int OUT_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             adc_start,
    input logic             adc_done,
    input logic             res_valid,
    input logic [OUT_W-1:0] res_data,
    input logic             eos,
    input logic             busy,
    input logic             tag_id
);

    logic outstanding_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          outstanding_q <= 1'b0;
        else if (adc_start)  outstanding_q <= 1'b1;
        else if (adc_done)   outstanding_q <= 1'b0;
    end

    a_r12_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> !outstanding_q);

    a_r12_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start);

    a_r7_eos_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        eos |-> !busy);

    a_r7_eos_single: assert property (@(posedge clk) disable iff (!rst_n)
        eos |=> !eos);

    a_r7_eos_after_result: assert property (@(posedge clk) disable iff (!rst_n)
        eos |-> $past(res_valid));

    a_r2_result_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> busy);

    a_r6_zero_gap: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_data[15:12] == 4'd0));

    a_r6_no_tag: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !$past(tag_id)) |-> (res_data[OUT_W-1:16] == '0));

endmodule

bind adc_step_sequencer seq_checker #(.OUT_W(OUT_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .adc_start (adc_start),
    .adc_done  (adc_done),
    .res_valid (res_valid),
    .res_data  (res_data),
    .eos       (eos),
    .busy      (busy),
    .tag_id    (tag_id)
);

// File: tb/adc_step_sequencer_tb_top.sv
`timescale 1ns/1ps
module adc_step_sequencer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tbl_we = 1'b0;
    logic [3:0]  tbl_addr = '0;
    logic [31:0] tbl_cfg = '0;
    logic [31:0] tbl_dly = '0;
    logic [17:0] chg_open_dly = '0;
    logic [16:0] step_mask = '0;
    logic        seq_start = 1'b0;
    logic        seq_enable = 1'b0;
    logic        tag_id = 1'b0;
    logic        hw_trig = 1'b0;
    logic        adc_start;
    logic        adc_done = 1'b0;
    logic [11:0] adc_data = '0;
    logic        res_valid;
    logic        res_fifo1;
    logic [19:0] res_data;
    logic        eos;
    logic        busy;

    always #5 clk = ~clk;

    adc_step_sequencer dut_i (
        .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
        .tbl_cfg(tbl_cfg), .tbl_dly(tbl_dly), .chg_open_dly(chg_open_dly),
        .step_mask(step_mask), .seq_start(seq_start), .seq_enable(seq_enable),
        .tag_id(tag_id), .hw_trig(hw_trig), .adc_start(adc_start),
        .adc_done(adc_done), .adc_data(adc_data), .res_valid(res_valid),
        .res_fifo1(res_fifo1), .res_data(res_data), .eos(eos), .busy(busy)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int adc_n = 0;
    int pred_n = 0;
    int adc_wait = 0;
    int adc_reqs = 0;
    int res_cnt = 0;
    int eos_cnt = 0;
    int last_eos_cyc = 0;
    int eos_gap = 0;
    bit gap_armed = 0;
    int start_cyc = 0;
    int first_gap = 0;
    bit start_armed = 0;
    logic [20:0] exp_q [$];

    function automatic logic [11:0] adc_val(int n);
        return 12'((n * 293 + 71) % 4096);
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Behavioural converter: 13 cycles per conversion
    always @(negedge clk) begin
        adc_done <= 1'b0;
        if (adc_start) begin
            check(adc_wait == 0, "R12", "request while outstanding", adc_wait, 0);
            adc_wait <= 13;
            adc_reqs <= adc_reqs + 1;
        end else if (adc_wait != 0) begin
            adc_wait <= adc_wait - 1;
            if (adc_wait == 1) begin
                adc_done <= 1'b1;
                adc_data <= adc_val(adc_n);
                adc_n    <= adc_n + 1;
            end
        end
    end

    // Monitor: pops the scoreboard as results appear
    always @(negedge clk) begin
        if (res_valid) begin
            res_cnt++;
            if (exp_q.size() == 0) begin
                check(0, "R2", "unexpected result", int'(res_data), -1);
            end else begin
                logic [20:0] e;
                e = exp_q.pop_front();
                check(res_data == e[19:0], "R3/R6", "result word", int'(res_data), int'(e[19:0]));
                check(res_fifo1 == e[20], "R5", "queue select", int'(res_fifo1), int'(e[20]));
            end
        end
        if (eos) begin
            check(!busy, "R7", "busy during eos", int'(busy), 0);
            eos_cnt++;
            last_eos_cyc = cyc;
            gap_armed = 1;
        end
        if (adc_start) begin
            if (gap_armed) begin eos_gap = cyc - last_eos_cyc; gap_armed = 0; end
            if (start_armed) begin first_gap = cyc - start_cyc; start_armed = 0; end
        end
    end

    task automatic write_step(int idx, int mode, int avg, bit f1, int opn, int smp);
        @(posedge clk); #1;
        tbl_we   = 1'b1;
        tbl_addr = 4'(idx);
        tbl_cfg  = (32'(f1) << 26) | (32'(avg) << 2) | 32'(mode) | 32'h0007_8000;
        tbl_dly  = (32'(smp) << 24) | 32'(opn);
        @(posedge clk); #1;
        tbl_we   = 1'b0;
    endtask

    // Driver side of the scoreboard: predicts one step's result
    task automatic push_step(int idx, int avg, bit f1, bit tag);
        int sum = 0;
        logic [19:0] w;
        for (int k = 0; k < (1 << avg); k++) begin
            sum += int'(adc_val(pred_n));
            pred_n++;
        end
        w = {(tag ? 4'(idx) : 4'd0), 4'd0, 12'(sum >> avg)};
        exp_q.push_back({f1, w});
    endtask

    task automatic pulse_start(logic [16:0] m);
        @(posedge clk); #1;
        step_mask = m;
        seq_start = 1'b1;
        start_cyc = cyc;
        start_armed = 1;
        @(posedge clk); #1;
        seq_start = 1'b0;
    endtask

    task automatic wait_eos(int target);
        while (eos_cnt < target) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "ALL", "watchdog expired", cyc, 0);
        finish_run();
    end

    initial begin
        int r0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(busy == 0, "R1", "busy after reset", int'(busy), 0);
        check(adc_start == 0, "R1", "adc_start after reset", int'(adc_start), 0);
        check(res_valid == 0, "R1", "res_valid after reset", int'(res_valid), 0);
        check(eos == 0, "R1", "eos after reset", int'(eos), 0);
        #1 rst_n = 1'b1;

        // R2 R3 R4 R5: three enabled steps with gaps, one configured but disabled
        write_step(1, 0, 0, 0, 5, 2);
        write_step(4, 0, 2, 1, 0, 0);
        write_step(6, 0, 1, 1, 1, 1);
        write_step(9, 0, 4, 0, 20, 3);
        push_step(1, 0, 0, 0);
        push_step(4, 2, 1, 0);
        push_step(9, 4, 0, 0);
        pulse_start(17'(1 << 2) | 17'(1 << 5) | 17'(1 << 10));
        @(negedge clk);
        check(busy == 1, "R7", "busy while running", int'(busy), 1);
        wait_eos(1);
        check(first_gap >= 7, "R4", "cycles to first request", first_gap, 7);
        check(exp_q.size() == 0, "R2", "pending results", exp_q.size(), 0);
        check(res_cnt == 3, "R2", "result count", res_cnt, 3);
        repeat (5) @(negedge clk);
        check(busy == 0, "R8", "idle after one-shot pass", int'(busy), 0);

        // R6 R3: boundary indices with tag, averaging code 5
        tag_id = 1'b1;
        write_step(0, 0, 5, 0, 2, 0);
        write_step(15, 0, 1, 1, 0, 4);
        push_step(0, 5, 0, 1);
        push_step(15, 1, 1, 1);
        pulse_start(17'(1 << 1) | 17'(1 << 16));
        wait_eos(2);
        check(exp_q.size() == 0, "R6", "pending tagged results", exp_q.size(), 0);
        tag_id = 1'b0;

        // R11: empty step mask (charge bit only) is ignored
        r0 = res_cnt;
        pulse_start(17'h1);
        repeat (20) @(negedge clk);
        check(busy == 0, "R11", "busy after empty-mask start", int'(busy), 0);
        check(res_cnt == r0, "R11", "results after empty-mask start", res_cnt, r0);

        // R11: start while busy is ignored
        write_step(3, 0, 0, 0, 100, 0);
        write_step(7, 0, 0, 1, 0, 0);
        push_step(3, 0, 0, 0);
        pulse_start(17'(1 << 4));
        repeat (10) @(posedge clk);
        pulse_start(17'(1 << 8));
        wait_eos(3);
        repeat (30) @(negedge clk);
        check(res_cnt == r0 + 1, "R11", "results after busy start", res_cnt, r0 + 1);
        check(busy == 0, "R11", "busy after single pass", int'(busy), 0);

        // R8 R10: one-shot plus continuous step, charge interval between passes
        chg_open_dly = 18'd60;
        seq_enable = 1'b1;
        write_step(2, 0, 1, 0, 2, 1);
        write_step(5, 1, 0, 1, 3, 1);
        push_step(2, 1, 0, 0);
        push_step(5, 0, 1, 0);
        push_step(5, 0, 1, 0);
        r0 = res_cnt;
        pulse_start(17'h1 | 17'(1 << 3) | 17'(1 << 6));
        wait_eos(4);
        while (gap_armed) @(negedge clk);
        seq_enable = 1'b0;
        check(eos_gap >= 60, "R10", "cycles from eos to next request", eos_gap, 60);
        wait_eos(5);
        repeat (100) @(negedge clk);
        check(res_cnt == r0 + 3, "R8", "results over two passes", res_cnt, r0 + 3);
        check(busy == 0, "R8", "idle after enable dropped", int'(busy), 0);
        check(eos_cnt == 5, "R8", "end-of-sequence count", eos_cnt, 5);

        // R9: hardware-synchronised step waits for the trigger
        write_step(3, 2, 0, 1, 2, 1);
        push_step(3, 0, 1, 0);
        r0 = adc_reqs;
        pulse_start(17'(1 << 4));
        repeat (80) @(negedge clk);
        check(adc_reqs == r0, "R9", "requests before trigger", adc_reqs, r0);
        check(busy == 1, "R9", "busy while waiting", int'(busy), 1);
        @(posedge clk); #1 hw_trig = 1'b1;
        @(posedge clk); #1 hw_trig = 1'b0;
        wait_eos(6);
        check(adc_reqs == r0 + 1, "R9", "requests after trigger", adc_reqs, r0 + 1);
        check(exp_q.size() == 0, "R9", "pending results", exp_q.size(), 0);

        repeat (10) @(posedge clk);
        finish_run();
    end

endmodule